// File: doc/BRIEF.md
# Parallel Polyphase x8 Interpolating Oversampler

This block raises the sample rate of a signed sample stream by eight without a faster clock. Each clock can present two consecutive input samples on two lanes. For each such pair the block returns sixteen output samples on sixteen lanes, and those lanes are in time order. Inside, a low-pass prototype filter is split into eight polyphase branches. Each branch serves both input lanes with a two-parallel fast FIR arrangement. That arrangement uses three half-length subfilters in place of four.

The filter advances only on clocks where the input valid flag is set. Gaps in the stream therefore do not change the result. The output valid flag tracks the input valid flag after a fixed three-cycle pipeline. Accumulation is carried at full precision. The block then scales each result by a power of two, rounds it and saturates it to the output width. The coefficients are fixed parameters. By default they form a symmetric triangular low-pass kernel that makes linear interpolation between neighbouring samples.

Top module: `x8_interp_ffa`

## Requirements
- R1: `out_valid` equals the value `in_valid` had three clock cycles earlier, and each accepted input pair yields exactly one output block.
- R2: While `out_valid` is low, `out_data` keeps its previous value.
- R3: Input lane 0 (`in_data[DW-1:0]`) holds the earlier sample of the pair. Output lane k sits at `out_data[k*OW +: OW]` and carries polyphase phase k mod 8 of input lane k div 8, so that the lanes run in time order.
- R4: With x[m] the sequence of accepted samples, the output for sample m and phase p is the sum over j from 0 to NT-1 of h[8j+p]·x[m-j]. The history across block boundaries is carried correctly.
- R5: Cycles with `in_valid` low do not advance the filter history, so idle gaps leave later outputs unchanged.
- R6: The default prototype is h[n] = 2048·(8-|n-7|) for n from 0 to 14 and 0 otherwise, with NT=4 and SHIFT=14. With this set, phase 7 reproduces its input sample exactly and phase p<7 gives ((p+1)·x[m]+(7-p)·x[m-1])/8.
- R7: During reset `out_valid` is 0, `out_data` is all zeros, and the filter history is zero, so the first outputs see zeros for the samples before the first one.
- R8: Rounding adds 2^(SHIFT-1) to the full-precision sum and then shifts right arithmetically by SHIFT, so exact halves round toward plus infinity.
- R9: A rounded value outside the signed OW-bit range is clamped to 2^(OW-1)-1 or -2^(OW-1).

Top module ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all lanes |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pair present this cycle |
| in_data | input | 2*DW | Two signed samples; lane 0 is the earlier one |
| out_valid | output | 1 | Output block present this cycle |
| out_data | output | 16*OW | Sixteen signed samples in time order |

## Verification
A single impulse separates the lane mapping from the phase coefficients. Ramps and alternating full-swing pairs exercise the even-odd crossing inside the fast FIR branches and the carry of history from one block to the next. Pairs placed between idle gaps show whether the history advances only on valid cycles. Small values chosen to land on exact halves, positive and negative, pin down the rounding direction. Large values fed to a second instance with one less shift bit drive both saturation limits.

// File: rtl/x8i_pkg.sv
package x8i_pkg;
  localparam int PHASES    = 8;
  localparam int IN_LANES  = 2;
  localparam int OUT_LANES = PHASES * IN_LANES;
  localparam int COEF_W    = 16;
  localparam int DEF_TAPS  = 4;
  localparam int LATENCY   = 3;
  localparam int DEF_LEN   = PHASES * DEF_TAPS;

  // Triangular kernel: linear interpolation, peak 0.5 in Q15 per phase sum.
  function automatic logic [DEF_LEN*COEF_W-1:0] default_coefs();
    logic [DEF_LEN*COEF_W-1:0] r;
    int d;
    r = '0;
    for (int n = 0; n < DEF_LEN; n++) begin
      d = (n > 7) ? (n - 7) : (7 - n);
      if (n <= 14) r[n*COEF_W +: COEF_W] = COEF_W'(2048 * (8 - d));
    end
    return r;
  endfunction
endpackage

// File: rtl/x8i_history.sv
module x8i_history #(
  parameter int DW = 16,
  parameter int HD = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [DW-1:0]         x0,
  input  logic [DW-1:0]         x1,
  output logic [HD*DW-1:0]      h0,
  output logic [HD*DW-1:0]      h1,
  output logic [HD*(DW+1)-1:0]  hs
);
  localparam int SW = DW + 1;

  logic [SW-1:0] sum_w;
  assign sum_w = {x0[DW-1], x0} + {x1[DW-1], x1};

  for (genvar g = 0; g < HD; g++) begin : g_stage
    logic [DW-1:0] src0, src1, nxt0, nxt1, q0, q1;
    logic [SW-1:0] srcs, nxts, qs;
    if (g == 0) begin : g_head
      assign src0 = x0;
      assign src1 = x1;
      assign srcs = sum_w;
    end else begin : g_tail
      assign src0 = q0_prev;
      assign src1 = q1_prev;
      assign srcs = qs_prev;
    end
    logic [DW-1:0] q0_prev, q1_prev;
    logic [SW-1:0] qs_prev;
    if (g == 0) begin : g_tie
      assign q0_prev = '0;
      assign q1_prev = '0;
      assign qs_prev = '0;
    end else begin : g_link
      assign q0_prev = h0[(g-1)*DW +: DW];
      assign q1_prev = h1[(g-1)*DW +: DW];
      assign qs_prev = hs[(g-1)*SW +: SW];
    end

    always_comb begin
      nxt0 = load ? src0 : q0;
      nxt1 = load ? src1 : q1;
      nxts = load ? srcs : qs;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q0 <= '0;
        q1 <= '0;
        qs <= '0;
      end else begin
        q0 <= nxt0;
        q1 <= nxt1;
        qs <= nxts;
      end
    end

    assign h0[g*DW +: DW] = q0;
    assign h1[g*DW +: DW] = q1;
    assign hs[g*SW +: SW] = qs;
  end
endmodule

// File: rtl/x8i_subfilter.sv
module x8i_subfilter #(
  parameter int              XW   = 16,
  parameter int              CW   = 16,
  parameter int              HD   = 2,
  parameter int              AW   = 40,
  parameter logic [HD*CW-1:0] COEF = '0
) (
  input  logic [HD*XW-1:0]     hist,
  output logic signed [AW-1:0] acc
);
  always_comb begin
    acc = '0;
    for (int i = 0; i < HD; i++) begin
      acc = acc + AW'($signed(hist[i*XW +: XW])) * AW'($signed(COEF[i*CW +: CW]));
    end
  end
endmodule

// File: rtl/x8i_ffa_branch.sv
module x8i_ffa_branch #(
  parameter int DW  = 16,
  parameter int CW  = 16,
  parameter int NT  = 4,
  parameter int AW  = 40,
  parameter int PH  = 0,
  parameter int NPH = 8,
  parameter logic [NPH*NT*CW-1:0] COEFS = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [(NT/2)*DW-1:0]     h0,
  input  logic [(NT/2)*DW-1:0]     h1,
  input  logic [(NT/2)*(DW+1)-1:0] hs,
  output logic signed [AW-1:0]     y_even,
  output logic signed [AW-1:0]     y_odd
);
  localparam int HD = NT / 2;
  localparam int SCW = CW + 1;

  function automatic logic [HD*CW-1:0] pick(input int odd);
    logic [HD*CW-1:0] r;
    for (int i = 0; i < HD; i++)
      r[i*CW +: CW] = COEFS[((2*i + odd)*NPH + PH)*CW +: CW];
    return r;
  endfunction

  function automatic logic [HD*SCW-1:0] pair_sum();
    logic [HD*SCW-1:0] r;
    for (int i = 0; i < HD; i++)
      r[i*SCW +: SCW] = SCW'($signed(COEFS[((2*i)*NPH + PH)*CW +: CW]))
                      + SCW'($signed(COEFS[((2*i + 1)*NPH + PH)*CW +: CW]));
    return r;
  endfunction

  localparam logic [HD*CW-1:0]  C_EVEN = pick(0);
  localparam logic [HD*CW-1:0]  C_ODD  = pick(1);
  localparam logic [HD*SCW-1:0] C_SUM  = pair_sum();

  logic signed [AW-1:0] a_w, b_w, c_w;

  x8i_subfilter #(.XW(DW), .CW(CW), .HD(HD), .AW(AW), .COEF(C_EVEN))
    u_sf_even (.hist(h0), .acc(a_w));
  x8i_subfilter #(.XW(DW), .CW(CW), .HD(HD), .AW(AW), .COEF(C_ODD))
    u_sf_odd  (.hist(h1), .acc(b_w));
  x8i_subfilter #(.XW(DW+1), .CW(SCW), .HD(HD), .AW(AW), .COEF(C_SUM))
    u_sf_sum  (.hist(hs), .acc(c_w));

  logic signed [AW-1:0] a_q, b_q, c_q, bp_q;
  logic signed [AW-1:0] a_d, b_d, c_d, bp_d;

  always_comb begin
    a_d  = en ? a_w : a_q;
    b_d  = en ? b_w : b_q;
    c_d  = en ? c_w : c_q;
    bp_d = en ? b_q : bp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      b_q  <= '0;
      c_q  <= '0;
      bp_q <= '0;
    end else begin
      a_q  <= a_d;
      b_q  <= b_d;
      c_q  <= c_d;
      bp_q <= bp_d;
    end
  end

  assign y_even = a_q + bp_q;
  assign y_odd  = c_q - a_q - b_q;
endmodule

// File: rtl/x8i_round_sat.sv
module x8i_round_sat #(
  parameter int AW = 40,
  parameter int OW = 16,
  parameter int SH = 14
) (
  input  logic signed [AW-1:0] acc,
  output logic [OW-1:0]        y
);
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (SH - 1);
  localparam logic signed [AW-1:0] MAXV = (AW'(1) <<< (OW - 1)) - AW'(1);
  localparam logic signed [AW-1:0] MINV = -MAXV - AW'(1);

  logic signed [AW-1:0] sh;

  always_comb begin
    sh = (acc + HALF) >>> SH;
    if (sh > MAXV)      y = MAXV[OW-1:0];
    else if (sh < MINV) y = MINV[OW-1:0];
    else                y = sh[OW-1:0];
  end
endmodule

// File: rtl/x8_interp_ffa.sv
module x8_interp_ffa #(
  parameter int DW    = 16,
  parameter int OW    = 16,
  parameter int NT    = x8i_pkg::DEF_TAPS,
  parameter int SHIFT = 14,
  parameter logic [x8i_pkg::PHASES*NT*x8i_pkg::COEF_W-1:0] COEFS = x8i_pkg::default_coefs()
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               in_valid,
  input  logic [x8i_pkg::IN_LANES*DW-1:0]    in_data,
  output logic                               out_valid,
  output logic [x8i_pkg::OUT_LANES*OW-1:0]   out_data
);
  import x8i_pkg::*;

  localparam int HD = NT / 2;
  localparam int CW = COEF_W;
  localparam int AW = DW + CW + 4 + $clog2(HD);

  logic [HD*DW-1:0]     h0_w, h1_w;
  logic [HD*(DW+1)-1:0] hs_w;

  x8i_history #(.DW(DW), .HD(HD)) u_hist (
    .clk(clk), .rst_n(rst_n), .load(in_valid),
    .x0(in_data[0 +: DW]), .x1(in_data[DW +: DW]),
    .h0(h0_w), .h1(h1_w), .hs(hs_w)
  );

  logic v1_q, v2_q, v1_d, v2_d;

  always_comb begin
    v1_d = in_valid;
    v2_d = v1_q;
  end

  logic signed [AW-1:0] acc_w [OUT_LANES];
  logic [OW-1:0]        rnd_w [OUT_LANES];

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    x8i_ffa_branch #(
      .DW(DW), .CW(CW), .NT(NT), .AW(AW), .PH(p), .NPH(PHASES), .COEFS(COEFS)
    ) u_branch (
      .clk(clk), .rst_n(rst_n), .en(v1_q),
      .h0(h0_w), .h1(h1_w), .hs(hs_w),
      .y_even(acc_w[p]), .y_odd(acc_w[PHASES + p])
    );
  end

  for (genvar k = 0; k < OUT_LANES; k++) begin : g_lane
    x8i_round_sat #(.AW(AW), .OW(OW), .SH(SHIFT)) u_rs (
      .acc(acc_w[k]), .y(rnd_w[k])
    );
  end

  logic [OUT_LANES*OW-1:0] od_q, od_d;
  logic                    ov_q, ov_d;

  always_comb begin
    od_d = od_q;
    if (v2_q) begin
      for (int k = 0; k < OUT_LANES; k++) od_d[k*OW +: OW] = rnd_w[k];
    end
    ov_d = v2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      ov_q <= 1'b0;
      od_q <= '0;
    end else begin
      v1_q <= v1_d;
      v2_q <= v2_d;
      ov_q <= ov_d;
      od_q <= od_d;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
endmodule

// File: rtl/x8i_check.sv
module x8i_check #(
  parameter int DW    = 16,
  parameter int OW    = 16,
  parameter int NT    = 4,
  parameter int SHIFT = 14,
  parameter logic [x8i_pkg::PHASES*NT*x8i_pkg::COEF_W-1:0] COEFS = '0
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             in_valid,
  input logic [x8i_pkg::IN_LANES*DW-1:0]  in_data,
  input logic                             out_valid,
  input logic [x8i_pkg::OUT_LANES*OW-1:0] out_data
);
  localparam bit PASS_OK = (NT == x8i_pkg::DEF_TAPS) && (SHIFT == 14) && (OW >= DW)
                           && (COEFS == x8i_pkg::default_coefs());

  logic [2:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  // R7: cleared outputs while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r7: assert (!out_valid && out_data == '0);
    end
  end

  // R1: fixed three-cycle valid pipeline
  p_valid_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd3) |-> (out_valid == $past(in_valid, 3)));

  // R2: output held between blocks
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd1 && !out_valid) |-> $stable(out_data));

  if (PASS_OK) begin : g_pass
    // R6: phase 7 is a pure delay of each input lane with the default set
    p_phase7_lane0_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 3'd3 && out_valid) |->
        ($signed(out_data[7*OW +: OW]) == $signed($past(in_data[0 +: DW], 3))));
    p_phase7_lane1_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 3'd3 && out_valid) |->
        ($signed(out_data[15*OW +: OW]) == $signed($past(in_data[DW +: DW], 3))));
  end
endmodule

bind x8_interp_ffa x8i_check #(
  .DW(DW), .OW(OW), .NT(NT), .SHIFT(SHIFT), .COEFS(COEFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/test_x8_interp_ffa.sv
module test_x8_interp_ffa;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int OW = 16;
  localparam int NT = 4;
  localparam int NL = 16;
  localparam logic [x8i_pkg::DEF_LEN*16-1:0] DEFC = x8i_pkg::default_coefs();

  logic clk, rst_n, in_valid;
  logic [2*DW-1:0] in_data;
  logic out_valid_a, out_valid_b;
  logic [NL*OW-1:0] out_a, out_b;

  x8_interp_ffa #(.DW(DW), .OW(OW), .NT(NT), .SHIFT(14)) i_x8_interp_ffa (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid_a), .out_data(out_a)
  );

  x8_interp_ffa #(.DW(DW), .OW(OW), .NT(NT), .SHIFT(13)) i_x8_interp_ffa_hi (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid_b), .out_data(out_b)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  int xs[$];
  logic [NL*OW-1:0] qa[$];
  logic [NL*OW-1:0] qb[$];
  string qt[$];
  int    qc[$];
  logic [NL*OW-1:0] last_a;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint coef(int n);
    return longint'($signed(DEFC[n*16 +: 16]));
  endfunction

  function automatic int yref(int m, int p, int sh);
    longint acc = 0;
    longint r;
    for (int j = 0; j < NT; j++) begin
      if (m - j >= 0) acc += coef(8*j + p) * longint'(xs[m - j]);
    end
    r = (acc + (longint'(1) <<< (sh - 1))) >>> sh;
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(input int a, input int b, input string tag);
    logic [NL*OW-1:0] ea, eb;
    int m0;
    xs.push_back(a);
    xs.push_back(b);
    m0 = xs.size() - 2;
    for (int k = 0; k < NL; k++) begin
      ea[k*OW +: OW] = OW'(yref(m0 + k/8, k%8, 14));
      eb[k*OW +: OW] = OW'(yref(m0 + k/8, k%8, 13));
    end
    qa.push_back(ea);
    qb.push_back(eb);
    qt.push_back(tag);
    qc.push_back(cyc);
    in_data  = {DW'(b), DW'(a)};
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Monitor: compare each produced block against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid_a) begin
        if (qa.size() == 0) begin
          check(1'b0, "R1", "unexpected output block", 1, 0);
        end else begin
          logic [NL*OW-1:0] ea, eb;
          string t;
          int c0;
          ea = qa.pop_front();
          eb = qb.pop_front();
          t  = qt.pop_front();
          c0 = qc.pop_front();
          check(cyc - c0 == x8i_pkg::LATENCY, "R1", "latency", cyc - c0, x8i_pkg::LATENCY);
          check(out_valid_b == 1'b1, "R1", "second instance valid", out_valid_b, 1);
          for (int k = 0; k < NL; k++) begin
            if (out_a[k*OW +: OW] != ea[k*OW +: OW]) begin
              check(1'b0, t, $sformatf("lane %0d", k),
                    $signed(out_a[k*OW +: OW]), $signed(ea[k*OW +: OW]));
            end
            if (out_b[k*OW +: OW] != eb[k*OW +: OW]) begin
              check(1'b0, (t == "R9") ? "R9" : t, $sformatf("shift13 lane %0d", k),
                    $signed(out_b[k*OW +: OW]), $signed(eb[k*OW +: OW]));
            end
          end
          check(out_a == ea, t, "block", 0, 0);
          check(out_b == eb, t, "shift13 block", 0, 0);
        end
        last_a = out_a;
      end else begin
        // R2: data held between blocks
        check(out_a == last_a, "R2", "hold while idle",
              $signed(out_a[0 +: OW]), $signed(last_a[0 +: OW]));
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    last_a   = '0;
    repeat (3) @(negedge clk);
    // R7: reset state
    check(out_valid_a == 1'b0 && out_valid_b == 1'b0, "R7", "valid in reset", out_valid_a, 0);
    check(out_a == '0 && out_b == '0, "R7", "data in reset", $signed(out_a[0 +: OW]), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: impulse exposes lane order and phase weights (R7 zero history)
    send(8000, 0, "R3");
    send(0, 0, "R4");
    send(0, 0, "R4");
    // R4: ramp across block boundaries
    for (int i = 0; i < 5; i++) send(700 * i - 1000, 700 * i - 650, "R4");
    // R5: idle gaps between pairs must not move the history
    send(3000, -3000, "R5");
    idle(3);
    send(-5000, 7000, "R5");
    idle(1);
    send(1, 2, "R5");
    idle(2);
    // R8: exact half results, positive and negative
    send(0, 4, "R8");
    send(-4, 0, "R8");
    send(3, -5, "R8");
    // R6: default set passes phase 7 unchanged
    send(12345, -23456, "R6");
    send(-31000, 29000, "R6");
    // R9: large values clamp on the shift-13 instance
    send(32767, -32768, "R9");
    send(20000, 20000, "R9");
    send(-20000, -20000, "R9");
    // R4: alternating full swing
    for (int i = 0; i < 4; i++) send((i % 2) ? 15000 : -15000, (i % 2) ? -15000 : 15000, "R4");
    idle(6);
    check(qa.size() == 0, "R1", "blocks outstanding", qa.size(), 0);
    summary();
  end
endmodule